// File: doc/BRIEF.md
# Software-Armed Downcounting Watchdog

This block is a watchdog with one 8-bit control register. The upper bit is a sticky arm flag and the lower seven bits are a downcounter that software reloads by writing the register. While the watchdog is live, the counter steps down by one on each cycle in which the tick-enable input is high. When counter bit 6 changes from one to zero (0x40 to 0x3F), the block requests a system reset with a one-cycle pulse.

Software can set the arm flag but cannot clear it. Only the synchronous reset clears it. A strap input stands in for a factory option that keeps the watchdog live whatever the flag holds. A register write both refreshes the counter and may set the flag in the same cycle. Reads return the flag and the live count and have no side effects.

Top module: `wdog_ctl`

## Requirements
- R1: While `rst` is high, on the next clock edge `rd_data` becomes 0x7F (flag clear, counter all ones) and `reset_req` becomes 0.
- R2: A write with `wr_data[7]`=1 sets the arm flag. From the next cycle, `rd_data[7]` reads 1.
- R3: A write with `wr_data[7]`=0 leaves the arm flag unchanged. Once set, the flag stays 1 until `rst`.
- R4: Every write loads `wr_data[6:0]` into the counter. The new value is visible on `rd_data[6:0]` in the cycle after the write.
- R5: While the watchdog is live (flag set or `force_on` high), each cycle with `tick_en` high and no write lowers the counter by one. Cycles with `tick_en` low leave it unchanged.
- R6: When a tick moves the counter from 0x40 to 0x3F while live, `reset_req` is high in the first cycle in which `rd_data[6:0]` reads 0x3F, and low in the cycle after that.
- R7: While the flag is clear and `force_on` is low, ticks leave the counter unchanged and `reset_req` stays low.
- R8: With `force_on` high, the block counts and requests resets as if armed, while `rd_data[7]` still shows the real flag value.
- R9: A write that clears counter bit 6 while it is 1 requests a reset in the next cycle if the watchdog is live after the write. This includes a write that sets the flag in the same cycle.
- R10: When a write and a tick occur in the same cycle, the write wins. The counter takes `wr_data[6:0]` and does not decrement.
- R11: `rd_data` always equals {flag, counter}. Reading has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value: bit 7 arm request, bits 6:0 counter load |
| rd_data | output | 8 | Register value: bit 7 flag, bits 6:0 live count |
| tick_en | input | 1 | Count enable from an external prescaler |
| force_on | input | 1 | Strap that keeps the watchdog always live |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is a trip caused by a register write instead of a tick. The most extreme form is a single write that sets the flag and clears bit 6 of a counter whose bit 6 is set.

The stimulus reaches it by reloading from reset state with 0xBF. It also covers a refresh that lands on a tick cycle, to check that the write wins. The count-down trip is reached by loading 0x45 and ticking cycle by cycle. `reset_req` is watched on every cycle, so the test also confirms that no early pulse occurs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DEF_CNT_W = 7;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/wdog_arm.sv
module wdog_arm (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic arm_d,
  output logic arm_q
);
  // Sticky flag: only reset clears it.
  always_comb arm_d = arm_q | set_req;

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm_d;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      CNT_LOAD: cnt_d = load_val;
      CNT_DEC:  cnt_d = cnt_q - CNT_ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_INIT;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_trip.sv
module wdog_trip #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             req_q
);
  localparam int unsigned TRIP_BIT = CNT_W - 1;

  logic fall;
  always_comb fall = live & cnt_q[TRIP_BIT] & ~cnt_d[TRIP_BIT];

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= fall;
  end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned REG_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tick_en,
  input  logic             force_on,
  output logic             reset_req
);
  logic             arm_d, arm_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             live_now, live_next;
  cnt_op_e          op;

  wdog_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .set_req (wr_en & wr_data[REG_W-1]),
    .arm_d   (arm_d),
    .arm_q   (arm_q)
  );

  always_comb begin
    live_now  = arm_q | force_on;
    live_next = arm_d | force_on;
    if (wr_en)                    op = CNT_LOAD;
    else if (live_now && tick_en) op = CNT_DEC;
    else                          op = CNT_HOLD;
  end

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (wr_data[CNT_W-1:0]),
    .cnt_d    (cnt_d),
    .cnt_q    (cnt_q)
  );

  wdog_trip #(.CNT_W(CNT_W)) u_trip (
    .clk   (clk),
    .rst   (rst),
    .live  (live_next),
    .cnt_d (cnt_d),
    .cnt_q (cnt_q),
    .req_q (reset_req)
  );

  assign rd_data = {arm_q, cnt_q};
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk #(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned REG_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic             tick_en,
  input logic             force_on,
  input logic             reset_req
);
  localparam int unsigned TB = CNT_W - 1;

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> (rd_data == {1'b0, {CNT_W{1'b1}}}) && !reset_req);

  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1] |=> rd_data[REG_W-1]);

  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> $stable(rd_data[CNT_W-1:0]));

  p_trip_edge_r6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (!rd_data[TB] && $past(rd_data[TB])));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  p_no_req_idle_r7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (rd_data[REG_W-1] || $past(force_on)));
endmodule

bind wdog_ctl wdog_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .tick_en   (tick_en),
  .force_on  (force_on),
  .reset_req (reset_req)
);

// File: tb/tb_wdog_ctl.sv
module tb_wdog_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick_en = 1'b0;
  logic       force_on = 1'b0;
  logic       reset_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdog_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_en(tick_en), .force_on(force_on),
    .reset_req(reset_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // One write cycle, optionally with tick; sampled at the following negedge.
  task automatic do_write(input logic [7:0] v, input logic tk);
    @(negedge clk); wr_en = 1'b1; wr_data = v; tick_en = tk;
    @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
  endtask

  // n tick cycles; returns number of reset_req pulses seen.
  task automatic do_ticks(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); @(negedge clk) ;
      tick_en = 1'b0;
      if (reset_req) pulses++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset value", rd_data, 8'h7F);
    chk("R1 reset_req low", {7'd0, reset_req}, 8'h00);
  endtask

  task automatic t_inactive();
    int p;
    do_ticks(10, p);
    chk("R7 counter held while disarmed", rd_data, 8'h7F);
    chk("R7 no request while disarmed", p[7:0], 8'h00);
  endtask

  task automatic t_sticky();
    do_write(8'hD0, 1'b0);
    chk("R2 arm set / R4 load", rd_data, 8'hD0);
    do_write(8'h45, 1'b0);
    chk("R3 flag not cleared by write of 0", rd_data, 8'hC5);
    chk("R11 read repeat", rd_data, 8'hC5);
  endtask

  task automatic t_countdown();
    int p;
    do_ticks(5, p);
    chk("R5 five ticks", rd_data, 8'hC0);
    chk("R6 no early request", p[7:0], 8'h00);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R6 counter at 3F", rd_data, 8'hBF);
    chk("R6 request pulse", {7'd0, reset_req}, 8'h01);
    @(negedge clk);
    chk("R6 pulse one cycle", {7'd0, reset_req}, 8'h00);
    chk("R5 hold without tick", rd_data, 8'hBF);
  endtask

  task automatic t_priority();
    do_write(8'h70, 1'b1);
    chk("R10 write beats tick", rd_data, 8'hF0);
    chk("R10 no request on refresh", {7'd0, reset_req}, 8'h00);
  endtask

  task automatic t_write_trip();
    do_write(8'h3A, 1'b0);
    chk("R9 load with bit6 clear", rd_data, 8'hBA);
    chk("R9 request after write", {7'd0, reset_req}, 8'h01);
    @(negedge clk);
    chk("R9 request drops", {7'd0, reset_req}, 8'h00);
  endtask

  task automatic t_force();
    int p;
    do_reset();
    chk("R1 flag cleared by reset", rd_data, 8'h7F);
    force_on = 1'b1;
    do_write(8'h41, 1'b0);
    chk("R8 load with flag clear", rd_data, 8'h41);
    do_ticks(1, p);
    chk("R8 counts when forced", rd_data, 8'h40);
    chk("R8 no request yet", p[7:0], 8'h00);
    do_ticks(1, p);
    chk("R8 trip when forced, flag shows 0", rd_data, 8'h3F);
    chk("R8 request when forced", p[7:0], 8'h01);
    force_on = 1'b0;
    do_ticks(3, p);
    chk("R7 stops when strap released", rd_data, 8'h3F);
  endtask

  task automatic t_arm_and_trip();
    do_reset();
    do_write(8'hBF, 1'b0);
    chk("R9 arm and clear bit6 same write", rd_data, 8'hBF);
    chk("R9 request on arming write", {7'd0, reset_req}, 8'h01);
    @(negedge clk);
    chk("R11 state unchanged by reads", rd_data, 8'hBF);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: timeout actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_inactive();
    t_sticky();
    t_countdown();
    t_priority();
    t_write_trip();
    t_force();
    t_arm_and_trip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule